// File: doc/BRIEF.md
# Clock Page-Replacement Victim Selector

This block keeps per-frame usage state for a pool of physical memory frames and chooses which frame to evict when the memory system needs a free one. Each frame has a reference bit and a dirty bit. Every access to a frame sets its reference bit, and a write access also marks the frame dirty. A single command resets all reference bits together. A separate clean command clears one frame's dirty bit once that frame has been written back in the background.

When a victim is requested, a hand pointer sweeps the frames in circular order and examines one frame per clock cycle. A frame whose reference bit is set is spared for now: its bit is cleared and the hand moves on. The first frame found with a clear reference bit becomes the victim. The hand stays on the victim, and the next request starts from that point. The result carries the victim's dirty flag, so the caller can tell whether a write-back is needed before the frame is reused.

Top module: `clock_victim_sel`

## Requirements
- R1: After synchronous reset, `sel_busy` and `sel_done` are 0, `sel_victim` is 0, `sel_dirty` is 0, the hand is at frame 0 and all reference and dirty bits are 0.
- R2: A cycle with `use_valid` high sets the reference bit of frame `use_frame`. If `use_write` is also high, the same frame's dirty bit is set.
- R3: A cycle with `clear_ref_all` high clears every reference bit at the next clock edge.
- R4: During a search, a frame under the hand whose reference bit is 1 has that bit cleared, and the hand advances by one. The hand wraps from frame N-1 to frame 0.
- R5: A search stops at the first frame under the hand whose reference bit is 0. It reports that frame on `sel_victim`, and reports the frame's dirty bit on `sel_dirty`.
- R6: The hand keeps its position between searches and remains on the reported victim. A second search with no accesses in between returns the same frame.
- R7: Each cycle of a search examines exactly one frame. `sel_done` rises S+1 clock edges after the edge that accepts `sel_start`, where S is the number of referenced frames skipped.
- R8: When every reference bit is set and no accesses occur during the search, the search clears all N bits. It returns the frame where it started after N+1 examinations.
- R9: When a use-port set and a sweep clear target the same frame in the same cycle, the reference bit ends up set.
- R10: `sel_done` is high for exactly one cycle per accepted search. `sel_start` is ignored while `sel_busy` is high.
- R11: A cycle with `clean_valid` high clears the dirty bit of frame `clean_frame`. A later search that selects that frame reports `sel_dirty` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | An access to frame `use_frame` occurs this cycle |
| use_frame | input | IW | Index of the accessed frame |
| use_write | input | 1 | The access is a write (marks the frame dirty) |
| clear_ref_all | input | 1 | Clear all reference bits |
| clean_valid | input | 1 | Frame `clean_frame` has been written back |
| clean_frame | input | IW | Index of the frame to mark clean |
| sel_start | input | 1 | Request a victim search |
| sel_busy | output | 1 | A search is in progress |
| sel_done | output | 1 | One-cycle pulse: the victim result is valid |
| sel_victim | output | IW | Index of the chosen victim frame |
| sel_dirty | output | 1 | Dirty bit of the chosen victim |

## Verification
The hardest case to reach from the ports is a use-port set that lands on a frame in the same cycle the sweep is clearing it. The hand's position is not visible, so the stimulus starts from a known hand position with every bit set. It then drives the access to that frame in the first examination cycle after the start is accepted. If the set wins, the sweep makes a second full lap and picks the following frame, which is a different victim with a longer latency. Wrap-around and hand persistence are reached through a chain of searches. The expected hand position of each search follows from the victims of the searches before it.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_valid,
  input  logic [IW-1:0] set_idx,
  input  logic          clear_all,
  input  logic          sweep_clr,
  input  logic [IW-1:0] sweep_idx,
  output logic [N-1:0]  ref_q
);

  // One flop per frame; a set from the use port overrides both clears.
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = ref_q[g];
      if (clear_all) bit_d = 1'b0;
      if (sweep_clr && (sweep_idx == IW'(g))) bit_d = 1'b0;
      if (set_valid && (set_idx == IW'(g))) bit_d = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) ref_q[g] <= 1'b0;
      else     ref_q[g] <= bit_d;
    end
  end

endmodule

// File: rtl/dirty_bit_array.sv
module dirty_bit_array #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark_valid,
  input  logic [IW-1:0] mark_idx,
  input  logic          clean_valid,
  input  logic [IW-1:0] clean_idx,
  output logic [N-1:0]  dirty_q
);

  // A write in the same cycle as a clean keeps the frame dirty.
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = dirty_q[g];
      if (clean_valid && (clean_idx == IW'(g))) bit_d = 1'b0;
      if (mark_valid && (mark_idx == IW'(g)))   bit_d = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) dirty_q[g] <= 1'b0;
      else     dirty_q[g] <= bit_d;
    end
  end

endmodule

// File: rtl/clock_hand_fsm.sv
module clock_hand_fsm
  import clock_sel_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N-1:0]  ref_q,
  input  logic [N-1:0]  dirty_q,
  output logic          sweep_clr,
  output logic [IW-1:0] hand_q,
  output logic          busy,
  output logic          done_q,
  output logic [IW-1:0] victim_q,
  output logic          vdirty_q
);

  scan_state_e   state_q;
  logic [IW-1:0] hand_nxt;
  logic          cur_ref;

  // Modulo-N advance: free wrap for powers of two, compare otherwise.
  if ((1 << IW) == N) begin : g_pow2
    assign hand_nxt = hand_q + 1'b1;
  end else begin : g_mod
    assign hand_nxt = (hand_q == IW'(N - 1)) ? '0 : hand_q + 1'b1;
  end

  assign cur_ref   = ref_q[hand_q];
  assign sweep_clr = (state_q == SCAN_RUN) && cur_ref;
  assign busy      = (state_q == SCAN_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SCAN_IDLE;
      hand_q   <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
      vdirty_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SCAN_IDLE: begin
          if (start) state_q <= SCAN_RUN;
        end
        SCAN_RUN: begin
          if (cur_ref) begin
            hand_q <= hand_nxt;
          end else begin
            done_q   <= 1'b1;
            victim_q <= hand_q;
            vdirty_q <= dirty_q[hand_q];
            state_q  <= SCAN_IDLE;
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          use_valid,
  input  logic [IW-1:0] use_frame,
  input  logic          use_write,
  input  logic          clear_ref_all,
  input  logic          clean_valid,
  input  logic [IW-1:0] clean_frame,
  input  logic          sel_start,
  output logic          sel_busy,
  output logic          sel_done,
  output logic [IW-1:0] sel_victim,
  output logic          sel_dirty
);

  logic [N-1:0]  ref_q;
  logic [N-1:0]  dirty_q;
  logic          sweep_clr;
  logic [IW-1:0] hand_q;

  ref_bit_array #(.N(N)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .set_valid (use_valid),
    .set_idx   (use_frame),
    .clear_all (clear_ref_all),
    .sweep_clr (sweep_clr),
    .sweep_idx (hand_q),
    .ref_q     (ref_q)
  );

  dirty_bit_array #(.N(N)) u_dirty (
    .clk         (clk),
    .rst         (rst),
    .mark_valid  (use_valid && use_write),
    .mark_idx    (use_frame),
    .clean_valid (clean_valid),
    .clean_idx   (clean_frame),
    .dirty_q     (dirty_q)
  );

  clock_hand_fsm #(.N(N)) u_hand (
    .clk       (clk),
    .rst       (rst),
    .start     (sel_start),
    .ref_q     (ref_q),
    .dirty_q   (dirty_q),
    .sweep_clr (sweep_clr),
    .hand_q    (hand_q),
    .busy      (sel_busy),
    .done_q    (sel_done),
    .victim_q  (sel_victim),
    .vdirty_q  (sel_dirty)
  );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          use_valid,
  input logic [IW-1:0] use_frame,
  input logic          clear_ref_all,
  input logic          sel_start,
  input logic          sel_busy,
  input logic          sel_done,
  input logic [IW-1:0] sel_victim,
  input logic [N-1:0]  ref_q,
  input logic [IW-1:0] hand_q
);

  logic [IW-1:0] exp_hand;
  logic [IW+1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    exp_hand <= (hand_q == IW'(N - 1)) ? '0 : hand_q + 1'b1;
    if (rst || !sel_busy || use_valid) quiet_cnt <= '0;
    else                               quiet_cnt <= quiet_cnt + 1'b1;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sel_done |=> !sel_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sel_done |-> !sel_busy);

  // R6
  hand_on_victim_chk: assert property (@(posedge clk) disable iff (rst)
    sel_done |-> (hand_q == sel_victim));

  // R6
  hand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_busy && !sel_start) |=> $stable(hand_q));

  // R5
  victim_unref_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_done && !$past(use_valid)) |-> !ref_q[sel_victim]);

  // R2
  use_set_chk: assert property (@(posedge clk) disable iff (rst)
    use_valid |=> ref_q[$past(use_frame)]);

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_ref_all && !use_valid) |=> (ref_q == '0));

  // R4
  sweep_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_busy && ref_q[hand_q]) |=> (hand_q == exp_hand));

  // R4
  sweep_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_busy && ref_q[hand_q] && !(use_valid && use_frame == hand_q))
      |=> !ref_q[$past(hand_q)]);

  // R7
  scan_len_chk: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt <= (IW + 2)'(N + 1));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .use_valid     (use_valid),
  .use_frame     (use_frame),
  .clear_ref_all (clear_ref_all),
  .sel_start     (sel_start),
  .sel_busy      (sel_busy),
  .sel_done      (sel_done),
  .sel_victim    (sel_victim),
  .ref_q         (ref_q),
  .hand_q        (hand_q)
);

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          use_valid, use_write, clear_ref_all, clean_valid, sel_start;
  logic [IW-1:0] use_frame, clean_frame;
  logic          sel_busy, sel_done, sel_dirty;
  logic [IW-1:0] sel_victim;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clock_victim_sel #(.N(N)) u_dut (
    .clk (clk), .rst (rst),
    .use_valid (use_valid), .use_frame (use_frame), .use_write (use_write),
    .clear_ref_all (clear_ref_all),
    .clean_valid (clean_valid), .clean_frame (clean_frame),
    .sel_start (sel_start), .sel_busy (sel_busy), .sel_done (sel_done),
    .sel_victim (sel_victim), .sel_dirty (sel_dirty)
  );

  // Fields: [31:24] frames to touch, [23:16] of those written,
  // [15:12] expected victim, [11:8] expected dirty, [7:0] expected cycles.
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0001,
    32'h0704_3004,
    32'h7800_7005,
    32'h8301_2104,
    32'h0000_2101,
    32'h0400_3002,
    32'hFF00_3009,
    32'hFE00_0106
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic touch(input logic [7:0] rm, input logic [7:0] wm);
    for (int i = 0; i < N; i++) begin
      if (rm[i]) begin
        use_valid = 1'b1;
        use_frame = IW'(i);
        use_write = wm[i];
        @(negedge clk);
      end
    end
    use_valid = 1'b0;
    use_write = 1'b0;
  endtask

  task automatic search(output int cyc);
    sel_start = 1'b1;
    @(negedge clk);
    sel_start = 1'b0;
    cyc = 0;
    while (!sel_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int ndone;
    int first_k;
    int vic;
    rst = 1'b1; use_valid = 1'b0; use_write = 1'b0; use_frame = '0;
    clear_ref_all = 1'b0; clean_valid = 1'b0; clean_frame = '0; sel_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(sel_busy), 0);
    chk("R1 done", int'(sel_done), 0);
    chk("R1 victim", int'(sel_victim), 0);
    chk("R1 dirty", int'(sel_dirty), 0);

    // R2 R4 R5 R6 R7 R8 table of searches, hand carried across entries
    for (int e = 0; e < 8; e++) begin
      touch(VEC[e][31:24], VEC[e][23:16]);
      search(cyc);
      chk("R7 latency", cyc, int'(VEC[e][7:0]));
      chk("R5 victim", int'(sel_victim), int'(VEC[e][15:12]));
      chk("R2 dirty", int'(sel_dirty), int'(VEC[e][11:8]));
    end

    // R3 clear-all: all bits set then cleared, hand at 0 -> immediate victim 0
    touch(8'hFF, 8'h00);
    clear_ref_all = 1'b1;
    @(negedge clk);
    clear_ref_all = 1'b0;
    search(cyc);
    chk("R3 latency", cyc, 1);
    chk("R3 victim", int'(sel_victim), 0);

    // R9 set wins over sweep clear on frame 0 in the first examination cycle
    touch(8'hFF, 8'h00);
    sel_start = 1'b1;
    @(negedge clk);
    sel_start = 1'b0;
    use_valid = 1'b1;
    use_frame = '0;
    @(negedge clk);
    use_valid = 1'b0;
    cyc = 1;
    while (!sel_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 victim", int'(sel_victim), 1);
    chk("R9 latency", cyc, 10);

    // R11 clean frame 0 (written earlier), then sweep onto it
    clean_valid = 1'b1;
    clean_frame = '0;
    @(negedge clk);
    clean_valid = 1'b0;
    touch(8'hFE, 8'h00);
    search(cyc);
    chk("R11 victim", int'(sel_victim), 0);
    chk("R11 dirty", int'(sel_dirty), 0);
    chk("R11 latency", cyc, 8);

    // R10 start held while busy: exactly one done, no second search
    touch(8'hFF, 8'h00);
    sel_start = 1'b1;
    ndone = 0;
    first_k = 0;
    vic = -1;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (k == 4) sel_start = 1'b0;
      if (sel_done) begin
        ndone++;
        if (first_k == 0) begin
          first_k = k;
          vic = int'(sel_victim);
        end
      end
    end
    chk("R10 done count", ndone, 1);
    chk("R10 done cycle", first_k, 10);
    chk("R8 victim", vic, 0);
    chk("R10 busy after", int'(sel_busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule